// File: doc/BRIEF.md
# Decimated-Sample Serial Lane Formatter

This block takes 16-bit decimated samples, complex I/Q pairs or a real stream, and places them on one or two serial data lanes. With each lane it produces a frame marker and a double-data-rate bit clock. A single fast clock drives everything. The block advances by one bit time on each cycle in which `bit_en_i` is high. Static configuration inputs select complex or real data and the lane mode: two lanes, one lane, or half-wire. In half-wire mode two channels share lane 0.

Samples arrive with a valid strobe and go into a hold register at any time. The hold register moves into the lane shifters only at a frame boundary, so a frame always carries one coherent set of words. In real two-lane mode, one frame carries two consecutive samples. These arrive together: the earlier one on `a_re_i` and the later one on `a_im_i`. In every other real mode only the real inputs are used.

Top module: `lane_formatter`

## Requirements
- R1: The frame length in bit times depends on `lane_mode_i` and `cplx_i`. For `lane_mode_i` = 00 (two lanes) it is 16 in both data modes. For 01 (one lane) it is 32 when complex and 16 when real. For 10 (half-wire) it is 64 when complex and 32 when real. Code 11 behaves exactly like 01.
- R2: `frame_o` is high during the first half of the bit times of each frame and low during the second half. It rises on the first bit of a frame.
- R3: `dclk_o` is high on even bit positions of a frame (the first bit is position 0) and low on odd positions. It therefore changes at every bit time, at half the lane bit rate.
- R4: A cycle with `bit_en_i` low changes none of `lane_o`, `frame_o` or `dclk_o`.
- R5: In two-lane mode each frame sends word 0 then word 1, MSB first. Lane 0 (`lane_o[0]`) carries bits 15..8 of each word and lane 1 carries bits 7..0. Word 0 is `a_re_i` and word 1 is `a_im_i`. These are I then Q in complex mode, and the earlier then the later sample in real mode.
- R6: In one-lane mode lane 0 sends `a_re_i`, then `a_im_i` when complex, each MSB first. Lane 1 stays low.
- R7: In half-wire mode lane 0 sends `a_re_i`, `a_im_i`, `b_re_i`, `b_im_i` when complex, and `a_re_i`, `b_re_i` when real, each 16 bits MSB first. Lane 1 stays low.
- R8: A frame carries the input words held just before the clock edge that ends the previous frame. A strobe that is sampled at that edge (during the last bit time) first appears one frame later.
- R9: If no valid strobe arrives during a frame, the next frame repeats the previous words. If several strobes arrive, the words of the last one are sent.
- R10: While `rst_ni` is low, both lanes are low, `frame_o` is high and `dclk_o` is high. The first frame after reset carries all-zero data.
- R11: `valid_i` captures the input words at every clock edge where it is high, whether or not `bit_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-time clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Advance one bit time on this cycle |
| cplx_i | input | 1 | 1: complex I/Q data, 0: real data (static) |
| lane_mode_i | input | 2 | 00 two lanes, 01 one lane, 10 half-wire, 11 as 01 (static) |
| valid_i | input | 1 | Capture strobe for the input words |
| a_re_i | input | 16 | Channel A real/I word, or earlier real sample |
| a_im_i | input | 16 | Channel A Q word, or later real sample in two-lane real mode |
| b_re_i | input | 16 | Channel B real/I word (half-wire only) |
| b_im_i | input | 16 | Channel B Q word (half-wire complex only) |
| lane_o | output | 2 | Serial data lanes, bit 0 is lane 0 |
| frame_o | output | 1 | Frame marker |
| dclk_o | output | 1 | Double-data-rate bit clock |

## Verification
A bit counter that is off by one shows up on the same cycle: `frame_o` and `dclk_o` fall out of phase with the model and the lane bits shift position. A wrong frame length shows up by the first wrap, within 64 bit times. A hold register that loads at the wrong time, or a shifter that loads in mid-frame, shows up within one frame as wrong words on the lanes. The bench sweeps every mode code and data type with random words and random enable gaps. It places strobes early in a frame, twice in a frame, not at all, and on the last bit.

// File: rtl/lfmt_pkg.sv
package lfmt_pkg;

  typedef enum logic [1:0] {
    LM_TWO  = 2'b00,
    LM_ONE  = 2'b01,
    LM_HALF = 2'b10,
    LM_ALT  = 2'b11
  } lane_mode_e;

  // frame length in units of half a sample word
  function automatic int unsigned frame_halves(input logic cplx, input lane_mode_e m);
    case (m)
      LM_TWO:  return 2;
      LM_HALF: return cplx ? 8 : 4;
      default: return cplx ? 4 : 2;
    endcase
  endfunction

endpackage

// File: rtl/lfmt_frame_ctr.sv
module lfmt_frame_ctr
  import lfmt_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = $clog2(4 * SAMPLE_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             cplx_i,
  input  lane_mode_e       mode_i,
  output logic             last_o,
  output logic             frame_o,
  output logic             dclk_o
);
  localparam int LEN_W  = CNT_W + 1;
  localparam int HALF_W = SAMPLE_W / 2;

  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] len, cnt_ext;
  logic             dclk_q;

  assign len     = LEN_W'(frame_halves(cplx_i, mode_i) * HALF_W);
  assign cnt_ext = {1'b0, cnt_q};
  assign last_o  = (cnt_ext == len - LEN_W'(1));
  assign frame_o = (cnt_ext < (len >> 1));
  assign dclk_o  = dclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dclk_q <= 1'b1;
    end else if (bit_en_i) begin
      cnt_q  <= last_o ? '0 : cnt_q + CNT_W'(1);
      dclk_q <= last_o ? 1'b1 : ~dclk_q;
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_ext < len);
  assert_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && last_o |=> cnt_q == '0);
  assert_frame_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_o) |-> cnt_q == '0);
  assert_dclk_toggle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i |=> dclk_q != $past(dclk_q));
  assert_dclk_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclk_q == ~cnt_q[0]);
  assert_ctr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(cnt_q) && $stable(dclk_q));

endmodule

// File: rtl/lfmt_sample_hold.sv
module lfmt_sample_hold #(
  parameter int SAMPLE_W  = 16,
  parameter int NUM_WORDS = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               valid_i,
  input  logic [NUM_WORDS-1:0][SAMPLE_W-1:0] words_i,
  output logic [NUM_WORDS-1:0][SAMPLE_W-1:0] hold_o
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [SAMPLE_W-1:0] w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      w_q <= '0;
      else if (valid_i) w_q <= words_i[g];
    end
    assign hold_o[g] = w_q;
  end

  assert_hold_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(hold_o));
  assert_hold_take_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> hold_o == $past(words_i));

endmodule

// File: rtl/lfmt_lane_pack.sv
module lfmt_lane_pack
  import lfmt_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int NUM_WORDS = 4,
  parameter int NUM_LANES = 2,
  parameter int FRAME_W   = NUM_WORDS * SAMPLE_W
) (
  input  logic                               cplx_i,
  input  lane_mode_e                         mode_i,
  input  logic [NUM_WORDS-1:0][SAMPLE_W-1:0] words_i,
  output logic [NUM_LANES-1:0][FRAME_W-1:0]  lane_data_o
);
  localparam int HALF_W = SAMPLE_W / 2;

  logic [SAMPLE_W-1:0] w0, w1, w2, w3;
  assign w0 = words_i[0];
  assign w1 = words_i[1];
  assign w2 = words_i[2];
  assign w3 = words_i[3];

  // payloads are MSB aligned; the frame length cuts off the unused tail
  always_comb begin
    lane_data_o = '0;
    case (mode_i)
      LM_TWO: begin
        lane_data_o[0] = {w0[SAMPLE_W-1:HALF_W], w1[SAMPLE_W-1:HALF_W],
                          {(FRAME_W - SAMPLE_W){1'b0}}};
        lane_data_o[1] = {w0[HALF_W-1:0], w1[HALF_W-1:0],
                          {(FRAME_W - SAMPLE_W){1'b0}}};
      end
      LM_HALF: begin
        if (cplx_i) lane_data_o[0] = {w0, w1, w2, w3};
        else        lane_data_o[0] = {w0, w2, {(FRAME_W - 2 * SAMPLE_W){1'b0}}};
      end
      default: lane_data_o[0] = {w0, w1, w2, w3};
    endcase
  end

endmodule

// File: rtl/lfmt_lane_shift.sv
module lfmt_lane_shift #(
  parameter int FRAME_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_en_i,
  input  logic               last_i,
  input  logic [FRAME_W-1:0] load_i,
  output logic               lane_o
);
  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (bit_en_i) sh_q <= last_i ? load_i : {sh_q[FRAME_W-2:0], 1'b0};
  end

  assign lane_o = sh_q[FRAME_W-1];

  assert_load_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && last_i |=> sh_q == $past(load_i));
  assert_shift_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(sh_q));

endmodule

// File: rtl/lane_formatter.sv
module lane_formatter
  import lfmt_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int NUM_LANES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_en_i,
  input  logic                 cplx_i,
  input  logic [1:0]           lane_mode_i,
  input  logic                 valid_i,
  input  logic [SAMPLE_W-1:0]  a_re_i,
  input  logic [SAMPLE_W-1:0]  a_im_i,
  input  logic [SAMPLE_W-1:0]  b_re_i,
  input  logic [SAMPLE_W-1:0]  b_im_i,
  output logic [NUM_LANES-1:0] lane_o,
  output logic                 frame_o,
  output logic                 dclk_o
);
  localparam int NUM_WORDS = 4;
  localparam int FRAME_W   = NUM_WORDS * SAMPLE_W;
  localparam int CNT_W     = $clog2(FRAME_W);

  lane_mode_e                         mode;
  logic                               last;
  logic [NUM_WORDS-1:0][SAMPLE_W-1:0] words, held;
  logic [NUM_LANES-1:0][FRAME_W-1:0]  lane_data;

  assign mode  = lane_mode_e'(lane_mode_i);
  assign words = {b_im_i, b_re_i, a_im_i, a_re_i};

  lfmt_frame_ctr #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .cplx_i   (cplx_i),
    .mode_i   (mode),
    .last_o   (last),
    .frame_o  (frame_o),
    .dclk_o   (dclk_o)
  );

  lfmt_sample_hold #(.SAMPLE_W(SAMPLE_W), .NUM_WORDS(NUM_WORDS)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .words_i (words),
    .hold_o  (held)
  );

  lfmt_lane_pack #(
    .SAMPLE_W(SAMPLE_W), .NUM_WORDS(NUM_WORDS), .NUM_LANES(NUM_LANES), .FRAME_W(FRAME_W)
  ) u_pack (
    .cplx_i      (cplx_i),
    .mode_i      (mode),
    .words_i     (held),
    .lane_data_o (lane_data)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    lfmt_lane_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .bit_en_i (bit_en_i),
      .last_i   (last),
      .load_i   (lane_data[l]),
      .lane_o   (lane_o[l])
    );
  end

  assert_lane1_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode != LM_TWO |-> lane_o[1] == 1'b0);
  assert_out_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(lane_o) && $stable(frame_o) && $stable(dclk_o));

endmodule

// File: tb/lane_formatter_test.sv
module lane_formatter_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_en_i = 1'b0;
  logic        cplx_i = 1'b0;
  logic [1:0]  lane_mode_i = 2'b00;
  logic        valid_i = 1'b0;
  logic [15:0] a_re_i = '0, a_im_i = '0, b_re_i = '0, b_im_i = '0;
  logic [1:0]  lane_o;
  logic        frame_o, dclk_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  lane_formatter uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .cplx_i(cplx_i),
    .lane_mode_i(lane_mode_i), .valid_i(valid_i), .a_re_i(a_re_i), .a_im_i(a_im_i),
    .b_re_i(b_re_i), .b_im_i(b_im_i), .lane_o(lane_o), .frame_o(frame_o), .dclk_o(dclk_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input int pos);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b (mode %0d cplx %0b bit %0d)",
               tag, act, exp, lane_mode_i, cplx_i, pos);
    end
  endtask

  // R1: frame length
  function automatic int flen(input bit c, input logic [1:0] m);
    case (m)
      2'b00:   return 16;
      2'b10:   return c ? 64 : 32;
      default: return c ? 32 : 16;
    endcase
  endfunction

  // expected lane bit at frame position k for payload words w (0:a_re 1:a_im 2:b_re 3:b_im)
  function automatic logic exp_lane(input int ln, input int k, input bit c,
                                    input logic [1:0] m, input logic [3:0][15:0] w);
    int wi;
    if (m == 2'b00) begin
      wi = k / 8;
      return (ln == 0) ? w[wi][15 - k % 8] : w[wi][7 - k % 8];
    end
    if (ln == 1) return 1'b0;
    wi = k / 16;
    if (m == 2'b10 && !c && wi == 1) wi = 2;
    return w[wi][15 - k % 16];
  endfunction

  task automatic run_cfg(input bit c, input logic [1:0] m, input int frames);
    int mcnt, len, f;
    logic [3:0][15:0] cur, hold;
    logic [1:0] pl;
    logic pf, pd;
    string tag;
    rst_ni = 1'b0; bit_en_i = 1'b0; valid_i = 1'b0;
    cplx_i = c; lane_mode_i = m;
    repeat (3) @(negedge clk_i);
    // R10: reset state
    chk("R10 lane0", lane_o[0], 1'b0, 0);
    chk("R10 lane1", lane_o[1], 1'b0, 0);
    chk("R10 frame", frame_o, 1'b1, 0);
    chk("R10 dclk", dclk_o, 1'b1, 0);
    rst_ni = 1'b1;
    len = flen(c, m); mcnt = 0; f = 0; cur = '0; hold = '0;
    case (m)
      2'b00:   tag = "R5 R8 R9 R11";
      2'b10:   tag = "R7 R8 R9 R11";
      default: tag = "R6 R8 R9 R11";
    endcase
    while (f < frames) begin
      if (f == 0) tag = {tag, " R10"};
      chk({tag, " lane0"}, lane_o[0], exp_lane(0, mcnt, c, m, cur), mcnt);
      chk({tag, " lane1"}, lane_o[1], exp_lane(1, mcnt, c, m, cur), mcnt);
      chk("R1 R2 frame", frame_o, (mcnt < len / 2), mcnt);
      chk("R3 dclk", dclk_o, (mcnt % 2 == 0), mcnt);
      pl = lane_o; pf = frame_o; pd = dclk_o;
      bit_en_i = ($urandom % 8) != 0;
      case (f % 4)
        0: valid_i = (mcnt == 3);
        1: valid_i = 1'b0;
        2: valid_i = (mcnt == 2) || (mcnt == 5);
        default: valid_i = (mcnt == len - 1);
      endcase
      a_re_i = 16'($urandom); a_im_i = 16'($urandom);
      b_re_i = 16'($urandom); b_im_i = 16'($urandom);
      @(posedge clk_i);
      if (bit_en_i) begin
        if (mcnt == len - 1) begin
          cur = hold; mcnt = 0; f++;
        end else mcnt++;
      end
      if (valid_i) hold = {b_im_i, b_re_i, a_im_i, a_re_i};
      @(negedge clk_i);
      if (!bit_en_i) begin  // R4
        chk("R4 lanes", (lane_o == pl), 1'b1, mcnt);
        chk("R4 frame", frame_o, pf, mcnt);
        chk("R4 dclk", dclk_o, pd, mcnt);
      end
      if (f == 1) tag = tag.substr(0, 11);
    end
    valid_i = 1'b0;
    bit_en_i = 1'b0;
  endtask

  initial begin
    for (int mi = 0; mi < 4; mi++) begin
      for (int ci = 0; ci < 2; ci++) begin
        run_cfg(ci[0], mi[1:0], 12);
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule